// File: doc/BRIEF.md
# Multi-Pipe Descriptor Scheduler with Atomic Locking

This block is the command front end of a peripheral that several processors share. Each of the six pipes presents one descriptor at a time through a valid/ready pair. The block picks one pipe and takes that pipe's head descriptor. A command descriptor carries one register element, and the block performs it as a single read or write on the peripheral register port. A data descriptor only marks a data-path step, so the block retires it without touching the register port.

Per-descriptor flags control the sequencing. INT requests a completion interrupt on the owning pipe. NWD holds back all further work until the peripheral signals that the current command has finished. LOCK and UNLOCK bracket a series of commands that no other pipe may interleave with. EOT marks the final data descriptor of a write. When a flag appears on a descriptor type that does not support it, the block ignores the flag and records the misuse in a sticky per-pipe error bit.

The block serves one descriptor at a time. A descriptor is accepted in one cycle (ready high), executes in the next cycle, and then either completes or waits for the peripheral acknowledge.

Top module: `pipe_desc_sched`

## Requirements
- R1: A command descriptor (type bit 1) accepted in cycle n drives exactly one single-cycle register access in cycle n+1, with its write bit, address, write data and pipe index. A data descriptor (type bit 0) produces no register access.
- R2: A command read returns the register port read data on the shared response data output, with the response valid bit of the issuing pipe high for one cycle, in the cycle after the access.
- R3: Flag bit 0 (INT) on either descriptor type gives a one-cycle pulse on the owning pipe's interrupt bit in the cycle after the descriptor completes.
- R4: Flag bit 1 (NWD) on a command descriptor means the descriptor completes only when the done acknowledge input is high. Until then no descriptor from any pipe is accepted and no register access is issued.
- R5: Without a lock, pending pipes are served round-robin, with the search starting after the last pipe served. After reset, pipe 0 has first priority.
- R6: Flag bit 2 (LOCK) on a command descriptor makes its pipe the lock owner once it completes. While the lock is held, only the owner is served.
- R7: Flag bit 3 (UNLOCK) on a command descriptor releases the lock only when that descriptor completes. The owner's descriptors before it are all served ahead of any other pipe.
- R8: A command descriptor carrying both LOCK and UNLOCK runs on its own and leaves the lock released, so the next grant follows round-robin order.
- R9: Flag bit 4 (EOT) on a data descriptor gives a one-cycle pulse on the owning pipe's end-of-transfer bit in the cycle after it completes.
- R10: LOCK, UNLOCK or NWD on a data descriptor, and EOT on a command descriptor, have no effect. Each such case sets that pipe's flag-error bit, which stays set until reset.
- R11: During and right after reset, ready, register request, response valid, interrupt, end-of-transfer and flag-error outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | NUM_PIPES | Per-pipe descriptor present |
| desc_ready_o | output | NUM_PIPES | Per-pipe descriptor taken this cycle |
| desc_cmd_i | input | NUM_PIPES | Per-pipe type bit, 1 = command |
| desc_flags_i | input | NUM_PIPES*5 | Per-pipe flags: INT, NWD, LOCK, UNLOCK, EOT in bits 0 to 4 |
| desc_we_i | input | NUM_PIPES | Per-pipe register write (1) or read (0) |
| desc_addr_i | input | NUM_PIPES*ADDR_W | Per-pipe register address |
| desc_wdata_i | input | NUM_PIPES*DATA_W | Per-pipe register write data |
| reg_req_o | output | 1 | Register access strobe |
| reg_we_o | output | 1 | Register access is a write |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_pipe_o | output | PIPE_W | Pipe issuing the access |
| reg_rdata_i | input | DATA_W | Read data, valid in the access cycle |
| done_ack_i | input | 1 | Peripheral completion acknowledge |
| rsp_valid_o | output | NUM_PIPES | Per-pipe read response valid |
| rsp_data_o | output | DATA_W | Read response data |
| irq_o | output | NUM_PIPES | Per-pipe completion interrupt pulse |
| eot_o | output | NUM_PIPES | Per-pipe end-of-transfer pulse |
| flag_err_o | output | NUM_PIPES | Per-pipe sticky flag-misuse bit |

## Verification
The scheduler is first loaded with three pipes holding two descriptors each. The expected order 0,1,2,0,1,2 separates round-robin service from fixed priority and from serving a pipe until it is empty. A locked three-command series is then raced against two other pending pipes, which shows whether the lock excludes them and when UNLOCK releases them. A combined LOCK+UNLOCK command followed by a competing pipe checks that no lock is left behind. An NWD command is held without an acknowledge for several cycles to confirm the stall and the late interrupt. Finally, descriptors with misplaced flags show that those flags neither stall nor lock the scheduler and that they set only the error bits of the pipes involved.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam int FLAG_W   = 5;
  localparam int F_INT    = 0;
  localparam int F_NWD    = 1;
  localparam int F_LOCK   = 2;
  localparam int F_UNLOCK = 3;
  localparam int F_EOT    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT} sched_state_t;

  typedef struct packed {
    logic irq;
    logic nwd;
    logic lock;
    logic unlock;
    logic eot;
    logic bad;
  } eff_flags_t;

  // Reduce raw flags to the ones that apply to this descriptor type.
  function automatic eff_flags_t decode_flags(input logic is_cmd,
                                              input logic [FLAG_W-1:0] f);
    eff_flags_t e;
    e.irq    = f[F_INT];
    e.nwd    = is_cmd & f[F_NWD];
    e.lock   = is_cmd & f[F_LOCK];
    e.unlock = is_cmd & f[F_UNLOCK];
    e.eot    = ~is_cmd & f[F_EOT];
    e.bad    = is_cmd ? f[F_EOT] : (f[F_NWD] | f[F_LOCK] | f[F_UNLOCK]);
    return e;
  endfunction

endpackage

// File: rtl/pds_arbiter.sv
module pds_arbiter #(
  parameter int NUM_PIPES = 6,
  parameter int PIPE_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] req,
  input  logic                 take,
  input  logic                 lock_held,
  input  logic [PIPE_W-1:0]    lock_owner,
  output logic [NUM_PIPES-1:0] grant,
  output logic [PIPE_W-1:0]    grant_idx,
  output logic                 grant_any
);

  logic [PIPE_W-1:0]    last_q;
  logic [NUM_PIPES-1:0] eligible;

  always_comb begin
    eligible = req;
    if (lock_held) begin
      eligible = '0;
      eligible[lock_owner] = req[lock_owner];
    end
  end

  // Search starts one past the last pipe served.
  always_comb begin
    int idx;
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 1; k <= NUM_PIPES; k++) begin
      idx = (int'(last_q) + k) % NUM_PIPES;
      if (!grant_any && eligible[idx]) begin
        grant_any = 1'b1;
        grant_idx = PIPE_W'(idx);
      end
    end
    grant = '0;
    if (grant_any) grant[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= PIPE_W'(NUM_PIPES - 1);
    else if (take) last_q <= grant_idx;
  end

  // R6: while locked, only the owner may be granted
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && grant_any) |-> (grant_idx == lock_owner));

endmodule

// File: rtl/pds_lock_ctl.sv
module pds_lock_ctl #(
  parameter int PIPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [PIPE_W-1:0] pipe,
  input  logic              set_lock,
  input  logic              clr_lock,
  output logic              held,
  output logic [PIPE_W-1:0] owner
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (fire) begin
      if (clr_lock) begin
        held <= 1'b0;
      end else if (set_lock) begin
        held  <= 1'b1;
        owner <= pipe;
      end
    end
  end

  // R7: a completed UNLOCK always leaves the lock free
  p_unlock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_lock) |=> !held);

  // R6: a completed LOCK alone makes its pipe the owner
  p_lock_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && set_lock && !clr_lock) |=> (held && owner == $past(pipe)));

endmodule

// File: rtl/pipe_desc_sched.sv
module pipe_desc_sched
  import pds_pkg::*;
#(
  parameter int NUM_PIPES = 6,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PIPES-1:0]          desc_valid_i,
  output logic [NUM_PIPES-1:0]          desc_ready_o,
  input  logic [NUM_PIPES-1:0]          desc_cmd_i,
  input  logic [NUM_PIPES*FLAG_W-1:0]   desc_flags_i,
  input  logic [NUM_PIPES-1:0]          desc_we_i,
  input  logic [NUM_PIPES*ADDR_W-1:0]   desc_addr_i,
  input  logic [NUM_PIPES*DATA_W-1:0]   desc_wdata_i,
  output logic                          reg_req_o,
  output logic                          reg_we_o,
  output logic [ADDR_W-1:0]             reg_addr_o,
  output logic [DATA_W-1:0]             reg_wdata_o,
  output logic [PIPE_W-1:0]             reg_pipe_o,
  input  logic [DATA_W-1:0]             reg_rdata_i,
  input  logic                          done_ack_i,
  output logic [NUM_PIPES-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_data_o,
  output logic [NUM_PIPES-1:0]          irq_o,
  output logic [NUM_PIPES-1:0]          eot_o,
  output logic [NUM_PIPES-1:0]          flag_err_o
);

  function automatic logic [NUM_PIPES-1:0] pipe_bit(input logic [PIPE_W-1:0] i);
    logic [NUM_PIPES-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  sched_state_t          state_q;
  logic [NUM_PIPES-1:0]  grant;
  logic [PIPE_W-1:0]     grant_idx;
  logic                  grant_any;
  logic                  lock_held;
  logic [PIPE_W-1:0]     lock_owner;

  logic [PIPE_W-1:0]     cur_pipe_q;
  logic                  cur_cmd_q;
  logic [FLAG_W-1:0]     cur_flags_q;
  logic                  cur_we_q;
  logic [ADDR_W-1:0]     cur_addr_q;
  logic [DATA_W-1:0]     cur_wdata_q;

  // named internal events
  logic                  take_desc;
  logic                  exec_cmd;
  logic                  desc_done;
  eff_flags_t            eff;

  logic [NUM_PIPES-1:0]  rsp_valid_q, irq_q, eot_q, flag_err_q;
  logic [DATA_W-1:0]     rsp_data_q;

  pds_arbiter #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (desc_valid_i),
    .take       (take_desc),
    .lock_held  (lock_held),
    .lock_owner (lock_owner),
    .grant      (grant),
    .grant_idx  (grant_idx),
    .grant_any  (grant_any)
  );

  assign eff       = decode_flags(cur_cmd_q, cur_flags_q);
  assign take_desc = (state_q == ST_IDLE) && grant_any;
  assign exec_cmd  = (state_q == ST_EXEC) && cur_cmd_q;
  assign desc_done = ((state_q == ST_EXEC) && !eff.nwd) ||
                     ((state_q == ST_WAIT) && done_ack_i);

  pds_lock_ctl #(.PIPE_W(PIPE_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (desc_done),
    .pipe     (cur_pipe_q),
    .set_lock (eff.lock),
    .clr_lock (eff.unlock),
    .held     (lock_held),
    .owner    (lock_owner)
  );

  assign desc_ready_o = (state_q == ST_IDLE) ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_desc) state_q <= ST_EXEC;
        ST_EXEC: state_q <= eff.nwd ? ST_WAIT : ST_IDLE;
        ST_WAIT: if (done_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pipe_q  <= '0;
      cur_cmd_q   <= 1'b0;
      cur_flags_q <= '0;
      cur_we_q    <= 1'b0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
    end else if (take_desc) begin
      cur_pipe_q  <= grant_idx;
      cur_cmd_q   <= desc_cmd_i[grant_idx];
      cur_flags_q <= desc_flags_i[int'(grant_idx)*FLAG_W +: FLAG_W];
      cur_we_q    <= desc_we_i[grant_idx];
      cur_addr_q  <= desc_addr_i[int'(grant_idx)*ADDR_W +: ADDR_W];
      cur_wdata_q <= desc_wdata_i[int'(grant_idx)*DATA_W +: DATA_W];
    end
  end

  assign reg_req_o   = exec_cmd;
  assign reg_we_o    = exec_cmd && cur_we_q;
  assign reg_addr_o  = cur_addr_q;
  assign reg_wdata_o = cur_wdata_q;
  assign reg_pipe_o  = cur_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
      irq_q       <= '0;
      eot_q       <= '0;
      flag_err_q  <= '0;
    end else begin
      rsp_valid_q <= (exec_cmd && !cur_we_q) ? pipe_bit(cur_pipe_q) : '0;
      if (exec_cmd && !cur_we_q) rsp_data_q <= reg_rdata_i;
      irq_q <= (desc_done && eff.irq) ? pipe_bit(cur_pipe_q) : '0;
      eot_q <= (desc_done && eff.eot) ? pipe_bit(cur_pipe_q) : '0;
      if ((state_q == ST_EXEC) && eff.bad)
        flag_err_q <= flag_err_q | pipe_bit(cur_pipe_q);
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign irq_o       = irq_q;
  assign eot_o       = eot_q;
  assign flag_err_o  = flag_err_q;

  // R1: each access lasts a single cycle
  p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_o |=> !reg_req_o);

  // R2: a response only follows a read access
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid_o) |-> $past(reg_req_o && !reg_we_o));

  // R3: at most one pipe interrupted per cycle
  p_irq_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  // R4: nothing moves while waiting for the acknowledge
  p_nwd_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (desc_ready_o == '0 && !reg_req_o));

  // R5: at most one pipe handed a grant
  p_ready_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(desc_ready_o));

  // R10: error bits never clear
  p_flag_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_err_o) & $past(flag_err_o)) == '0);

endmodule

// File: tb/pipe_desc_sched_tb_top.sv
module pipe_desc_sched_tb_top;

  localparam int NP = 6;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int PW = 3;
  localparam bit [4:0] FI = 5'd1, FN = 5'd2, FL = 5'd4, FU = 5'd8, FE = 5'd16;

  typedef struct {
    bit        cmd;
    bit [4:0]  flags;
    bit        we;
    bit [7:0]  addr;
    bit [31:0] wdata;
  } desc_t;

  typedef struct packed {
    bit [2:0]  p;
    bit        we;
    bit [7:0]  a;
    bit [31:0] w;
  } acc_t;

  typedef struct packed {
    bit [2:0]  p;
    bit [31:0] d;
  } rsp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]    desc_valid = '0;
  logic [NP-1:0]    desc_ready;
  logic [NP-1:0]    desc_cmd = '0;
  logic [NP*5-1:0]  desc_flags = '0;
  logic [NP-1:0]    desc_we = '0;
  logic [NP*AW-1:0] desc_addr = '0;
  logic [NP*DW-1:0] desc_wdata = '0;
  logic             reg_req, reg_we;
  logic [AW-1:0]    reg_addr;
  logic [DW-1:0]    reg_wdata, reg_rdata;
  logic [PW-1:0]    reg_pipe;
  logic             done_ack = 1'b0;
  logic [NP-1:0]    rsp_valid, irq, eot, flag_err;
  logic [DW-1:0]    rsp_data;

  function automatic bit [31:0] periph_read(bit [7:0] a);
    return {8'hC3, a, ~a, 8'h5A};
  endfunction

  assign reg_rdata = periph_read(reg_addr);

  pipe_desc_sched #(.NUM_PIPES(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
    .desc_cmd_i(desc_cmd), .desc_flags_i(desc_flags), .desc_we_i(desc_we),
    .desc_addr_i(desc_addr), .desc_wdata_i(desc_wdata),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_pipe_o(reg_pipe), .reg_rdata_i(reg_rdata),
    .done_ack_i(done_ack),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .irq_o(irq), .eot_o(eot), .flag_err_o(flag_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  int n_acc = 0;
  int n_irq = 0;
  bit gate = 1'b0;

  desc_t pq [NP][$];
  acc_t  exp_acc[$];
  rsp_t  exp_rsp[$];
  int    exp_irq[$];
  int    exp_eot[$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // driver: present queued descriptors, drop them once taken
  logic [NP-1:0] taken = '0;
  always @(posedge clk) taken <= desc_valid & desc_ready;

  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (taken[i] && pq[i].size() > 0) pq[i].delete(0);
      if (gate && pq[i].size() > 0) begin
        desc_valid[i]          = 1'b1;
        desc_cmd[i]            = pq[i][0].cmd;
        desc_flags[i*5 +: 5]   = pq[i][0].flags;
        desc_we[i]             = pq[i][0].we;
        desc_addr[i*AW +: AW]  = pq[i][0].addr;
        desc_wdata[i*DW +: DW] = pq[i][0].wdata;
      end else begin
        desc_valid[i] = 1'b0;
      end
    end
  end

  // queue a descriptor on a pipe
  task automatic put(int p, bit cmd, bit [4:0] f, bit we, bit [7:0] a, bit [31:0] w);
    desc_t d;
    d.cmd = cmd; d.flags = f; d.we = we; d.addr = a; d.wdata = w;
    pq[p].push_back(d);
  endtask

  // expected effects of one descriptor, pushed in expected service order
  task automatic expect_d(int p, bit cmd, bit [4:0] f, bit we, bit [7:0] a, bit [31:0] w);
    acc_t e;
    rsp_t r;
    if (cmd) begin
      e.p = 3'(p); e.we = we; e.a = a; e.w = w;
      exp_acc.push_back(e);
      if (!we) begin
        r.p = 3'(p); r.d = periph_read(a);
        exp_rsp.push_back(r);
      end
    end
    if (f[0]) exp_irq.push_back(p);
    if (!cmd && f[4]) exp_eot.push_back(p);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_req) begin
        acc_t a;
        n_acc++;
        a.p = reg_pipe; a.we = reg_we; a.a = reg_addr; a.w = reg_wdata;
        if (exp_acc.size() == 0)
          chk(1'b0, "R1 unexpected register access", 64'(a), 64'h0);
        else begin
          acc_t e;
          e = exp_acc.pop_front();
          chk(a == e, "R1/R5/R6 register access order and fields", 64'(a), 64'(e));
        end
      end
      if (|rsp_valid) begin
        rsp_t r;
        r.d = rsp_data;
        r.p = '0;
        for (int i = 0; i < NP; i++) if (rsp_valid[i]) r.p = 3'(i);
        if (exp_rsp.size() == 0)
          chk(1'b0, "R2 unexpected response", 64'(r), 64'h0);
        else begin
          rsp_t e;
          e = exp_rsp.pop_front();
          chk(r == e, "R2 read response", 64'(r), 64'(e));
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (irq[i]) begin
          n_irq++;
          if (exp_irq.size() == 0) chk(1'b0, "R3 unexpected interrupt", 64'(i), 64'h0);
          else begin
            int e;
            e = exp_irq.pop_front();
            chk(i == e, "R3 interrupt pipe", 64'(i), 64'(e));
          end
        end
        if (eot[i]) begin
          if (exp_eot.size() == 0) chk(1'b0, "R9 unexpected end-of-transfer", 64'(i), 64'h0);
          else begin
            int e;
            e = exp_eot.pop_front();
            chk(i == e, "R9 end-of-transfer pipe", 64'(i), 64'(e));
          end
        end
      end
    end
  end

  task automatic drain(string req);
    int left;
    bit busy;
    busy = 1'b1;
    for (int c = 0; c < 300 && busy; c++) begin
      @(negedge clk);
      left = 0;
      for (int i = 0; i < NP; i++) left += pq[i].size();
      busy = (left != 0);
    end
    repeat (4) @(negedge clk);
    chk(!busy, {req, " all descriptors served"}, 64'(left), 64'h0);
    chk(exp_acc.size() == 0 && exp_rsp.size() == 0 && exp_irq.size() == 0 &&
        exp_eot.size() == 0, {req, " all expected events seen"},
        64'(exp_acc.size() + exp_rsp.size() + exp_irq.size() + exp_eot.size()), 64'h0);
    gate = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk({desc_ready, reg_req, rsp_valid, irq, eot, flag_err} == '0,
        "R11 outputs low in reset", 64'({reg_req, irq, flag_err}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({desc_ready, reg_req, rsp_valid, irq, eot, flag_err} == '0,
        "R11 outputs low after reset", 64'({reg_req, irq, flag_err}), 64'h0);

    // R5 round-robin: expected 0,1,2,0,1,2 (R2 read on pipe 1)
    put(0, 1, FI, 1, 8'h10, 32'hA0); put(0, 1, 0, 1, 8'h11, 32'hA1);
    put(1, 1, 0,  1, 8'h20, 32'hB0); put(1, 1, FI, 0, 8'h21, 32'h0);
    put(2, 1, 0,  1, 8'h30, 32'hC0); put(2, 1, 0, 0, 8'h31, 32'h0);
    expect_d(0, 1, FI, 1, 8'h10, 32'hA0);
    expect_d(1, 1, 0,  1, 8'h20, 32'hB0);
    expect_d(2, 1, 0,  1, 8'h30, 32'hC0);
    expect_d(0, 1, 0,  1, 8'h11, 32'hA1);
    expect_d(1, 1, FI, 0, 8'h21, 32'h0);
    expect_d(2, 1, 0,  0, 8'h31, 32'h0);
    gate = 1'b1;
    drain("R5");

    // R6/R7 lock series on pipe 3 against pipes 0 and 1
    put(3, 1, FL, 1, 8'h40, 32'hD0);
    put(3, 1, 0,  0, 8'h41, 32'h0);
    put(3, 1, FU, 1, 8'h42, 32'hD2);
    put(0, 1, 0,  1, 8'h50, 32'hE0);
    put(1, 1, 0,  1, 8'h60, 32'hF0);
    expect_d(3, 1, FL, 1, 8'h40, 32'hD0);
    expect_d(3, 1, 0,  0, 8'h41, 32'h0);
    expect_d(3, 1, FU, 1, 8'h42, 32'hD2);
    expect_d(0, 1, 0,  1, 8'h50, 32'hE0);
    expect_d(1, 1, 0,  1, 8'h60, 32'hF0);
    gate = 1'b1;
    drain("R6/R7");

    // R8 combined lock+unlock on pipe 4, then pipe 5 before pipe 4 again
    put(4, 1, FL | FU | FI, 1, 8'h70, 32'h70);
    put(4, 1, 0, 1, 8'h71, 32'h71);
    put(5, 1, 0, 1, 8'h80, 32'h80);
    expect_d(4, 1, FL | FU | FI, 1, 8'h70, 32'h70);
    expect_d(5, 1, 0, 1, 8'h80, 32'h80);
    expect_d(4, 1, 0, 1, 8'h71, 32'h71);
    gate = 1'b1;
    drain("R8");

    // R4 NWD on pipe 1 stalls pipe 2
    begin
      int a0, i0;
      put(1, 1, FN | FI, 1, 8'h90, 32'h90);
      put(2, 1, 0, 1, 8'h91, 32'h91);
      expect_d(1, 1, FN | FI, 1, 8'h90, 32'h90);
      expect_d(2, 1, 0, 1, 8'h91, 32'h91);
      a0 = n_acc;
      i0 = n_irq;
      gate = 1'b1;
      for (int c = 0; c < 50 && n_acc == a0; c++) @(negedge clk);
      a0 = n_acc;
      repeat (6) @(negedge clk);
      chk(n_acc == a0, "R4 no access while awaiting acknowledge", 64'(n_acc), 64'(a0));
      chk(n_irq == i0, "R4/R3 no interrupt before acknowledge", 64'(n_irq), 64'(i0));
      done_ack = 1'b1;
      @(negedge clk);
      done_ack = 1'b0;
      drain("R4");
    end

    // R10 misplaced flags, R9 end-of-transfer, R3 on data descriptor
    put(5, 0, FI | FL | FN, 0, 8'h00, 32'h0);
    put(0, 1, FE | FI, 1, 8'hA0, 32'hAA);
    put(1, 0, FE, 0, 8'h00, 32'h0);
    expect_d(5, 0, FI | FL | FN, 0, 8'h00, 32'h0);
    expect_d(0, 1, FE | FI, 1, 8'hA0, 32'hAA);
    expect_d(1, 0, FE, 0, 8'h00, 32'h0);
    gate = 1'b1;
    drain("R10");
    chk(flag_err == 6'b100001, "R10 flag-error bits", 64'(flag_err), 64'h21);

    // R10 sticky: a clean descriptor on pipe 0 leaves its bit set
    put(0, 1, 0, 1, 8'hB0, 32'hBB);
    expect_d(0, 1, 0, 1, 8'hB0, 32'hBB);
    gate = 1'b1;
    drain("R10 sticky");
    chk(flag_err == 6'b100001, "R10 flag-error bits stay set", 64'(flag_err), 64'h21);

    report();
  end

endmodule